// File: doc/BRIEF.md
# Edge-Select Input Capture Unit

This block time-stamps transitions on up to four external input pins. All channels share one free-running counter, and a programmable divider sets its rate. Each channel brings its pin into the clock domain, looks for the transition kind that its own edge-select field asks for, and on a match copies the current count into its capture register and raises its status flag.

Software reaches every setting through a simple register port. Writes take effect in the same cycle. A read returns its data one cycle after the request. Status flags stay set until software clears them through a write-only acknowledge address. A single interrupt line reports any flag that is both set and enabled.

Top module: `ecap_top`

## Requirements
- R1: After reset every readable register returns zero, `irq` is low and `rd_data` is zero.
- R2: The per-channel edge-select field takes these values: 0 captures nothing, 1 captures low-to-high, 2 captures high-to-low, and 3 captures both directions.
- R3: The divider field is at control register (0x50) bits 8:4 and holds a value p. While capture is enabled, the shared counter advances once every p+1 clocks. After k enabled clocks it reads floor(k/(p+1)). On a selected edge, the channel's capture register takes the counter value.
- R4: Control bit 10 enables capture. While it is low, the counter and divider are held at zero, and no capture register or status flag changes.
- R5: Channel n has its capture value at byte address 0x10+4n, which is read-only. Its edge-select field is read/write at address 0x30+4n, in bits 1:0.
- R6: A capture on channel n sets bit n+1 of the status register at 0x58. The interrupt enables are read/write at 0x54, and channel n's enable is bit n+1.
- R7: A write to 0x5C clears each status bit n+1 whose write-data bit n+1 is 1 and leaves the others unchanged. If a capture and its clear land in the same cycle, the flag stays set.
- R8: `irq` is a register. It is high one clock after any status bit and its matching enable bit are both 1.
- R9: Each pin passes through two synchronising flops and one history flop. A pin that changes before clock edge T+1 is captured at edge T+3, and the value taken is the one the counter held after edge T+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Read byte address |
| rd_data | output | DW | Read data, valid the cycle after `rd_en` |
| cap_pin | input | NCH | Asynchronous capture inputs, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
The bench predicts each capture value from the write cycle that enabled the counter and the cycle in which the pin changed. A synchroniser one flop short or long, or a divider off by one, therefore shows up as a wrong timestamp. It drives edges that a channel's mode must ignore, including any edge on a disabled channel. It also drives edges while capture is globally off, so a design that decodes the mode loosely or keeps counting sets a flag or moves a capture register. It acknowledges one flag while leaving another set, so a design that clears everything on any write loses the second event. Finally, it lands an acknowledge on the exact cycle of a new capture, so a design that gives the clear priority drops that event.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  localparam int unsigned CAPV_BASE  = 32'h10;
  localparam int unsigned EDGE_BASE  = 32'h30;
  localparam int unsigned CTRL_ADDR  = 32'h50;
  localparam int unsigned IEN_ADDR   = 32'h54;
  localparam int unsigned STAT_ADDR  = 32'h58;
  localparam int unsigned ACK_ADDR   = 32'h5C;

  localparam int unsigned PS_W       = 5;
  localparam int unsigned PS_LSB     = 4;
  localparam int unsigned EN_BIT     = 10;
  localparam int unsigned FLAG_LSB   = 1;

endpackage

// File: rtl/ecap_timebase.sv
module ecap_timebase #(
  parameter int CNT_W = 32,
  parameter int PS_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PS_W-1:0]  ps,
  output logic [CNT_W-1:0] cnt
);

  logic [PS_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
      cnt   <= '0;
    end else if (div_q == ps) begin
      div_q <= '0;
      cnt   <= cnt + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/ecap_channel.sv
module ecap_channel #(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 pin,
  input  ecap_pkg::edge_mode_e mode,
  input  logic [CNT_W-1:0]     cnt,
  output logic                 hit,
  output logic [CNT_W-1:0]     capv
);

  logic s1_q, s2_q, prev_q;
  logic rose, fell, match;

  assign rose = s2_q & ~prev_q;
  assign fell = ~s2_q & prev_q;

  always_comb begin
    unique case (mode)
      ecap_pkg::EDGE_RISE: match = rose;
      ecap_pkg::EDGE_FALL: match = fell;
      ecap_pkg::EDGE_ANY:  match = rose | fell;
      default:             match = 1'b0;
    endcase
  end

  assign hit = run & match;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      capv   <= '0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (hit) capv <= cnt;
    end
  end

endmodule

// File: rtl/ecap_top.sv
module ecap_top #(
  parameter int NCH   = 4,
  parameter int CNT_W = 32,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic [NCH-1:0] cap_pin,
  output logic           irq
);
  import ecap_pkg::*;

  localparam int FL_HI = FLAG_LSB + NCH - 1;

  logic [PS_W-1:0]  ps_q;
  logic             cap_en;
  logic [NCH-1:0]   ien;
  logic [NCH-1:0]   status;
  logic [NCH-1:0]   hit;
  logic [NCH-1:0]   ack_clr;
  logic [1:0]       edge_sel [NCH];
  logic [CNT_W-1:0] capv_arr [NCH];
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    rd_next;
  logic             ack_wr;
  logic             unused_wr;

  assign unused_wr = ^wr_data;
  assign ack_wr    = wr_en && (wr_addr == AW'(ACK_ADDR));
  assign ack_clr   = ack_wr ? wr_data[FL_HI:FLAG_LSB] : '0;

  ecap_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) tb_i (
    .clk (clk),
    .rst (rst),
    .run (cap_en),
    .ps  (ps_q),
    .cnt (cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) edge_sel[i] <= '0;
      else if (wr_en && wr_addr == AW'(EDGE_BASE + 4 * i)) edge_sel[i] <= wr_data[1:0];
    end

    ecap_channel #(.CNT_W(CNT_W)) ch_i (
      .clk  (clk),
      .rst  (rst),
      .run  (cap_en),
      .pin  (cap_pin[i]),
      .mode (edge_mode_e'(edge_sel[i])),
      .cnt  (cnt),
      .hit  (hit[i]),
      .capv (capv_arr[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q   <= '0;
      cap_en <= 1'b0;
      ien    <= '0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_en && wr_addr == AW'(CTRL_ADDR)) begin
        ps_q   <= wr_data[PS_LSB +: PS_W];
        cap_en <= wr_data[EN_BIT];
      end
      if (wr_en && wr_addr == AW'(IEN_ADDR)) ien <= wr_data[FL_HI:FLAG_LSB];
      status <= (status & ~ack_clr) | hit;
      irq    <= |(status & ien);
    end
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == AW'(CTRL_ADDR)) begin
      rd_next[PS_LSB +: PS_W] = ps_q;
      rd_next[EN_BIT]         = cap_en;
    end
    if (rd_addr == AW'(IEN_ADDR))  rd_next[FL_HI:FLAG_LSB] = ien;
    if (rd_addr == AW'(STAT_ADDR)) rd_next[FL_HI:FLAG_LSB] = status;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(CAPV_BASE + 4 * i)) rd_next = DW'(capv_arr[i]);
      if (rd_addr == AW'(EDGE_BASE + 4 * i)) rd_next[1:0] = edge_sel[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
    else            rd_data <= '0;
  end

endmodule

// File: rtl/ecap_chk.sv
module ecap_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cap_en,
  input logic [CNT_W-1:0] cnt,
  input logic [NCH-1:0]   status,
  input logic [NCH-1:0]   ien,
  input logic             ack_wr,
  input logic             irq
);

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> cnt == '0);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_en && $past(cap_en)) |-> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

  // R4
  no_new_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> ((status & ~$past(status)) == '0));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_wr |=> (($past(status) & ~status) == '0));

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|(status & ien)) |=> irq);

  // R8
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(status & ien)) |=> !irq);

endmodule

bind ecap_top ecap_chk #(.NCH(NCH), .CNT_W(CNT_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .cap_en (cap_en),
  .cnt    (cnt),
  .status (status),
  .ien    (ien),
  .ack_wr (ack_wr),
  .irq    (irq)
);

// File: tb/ecap_top_tb_top.sv
`timescale 1ns/1ps
module ecap_top_tb_top;

  localparam int NCH = 4;
  localparam int AW  = 8;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic           rd_en = 1'b0;
  logic [AW-1:0]  rd_addr = '0;
  logic [DW-1:0]  rd_data;
  logic [NCH-1:0] cap_pin = '0;
  logic           irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [AW-1:0] q_addr [$];
  logic [DW-1:0] q_exp  [$];
  string         q_tag  [$];
  logic          rd_fire = 1'b0;

  always #4 clk = ~clk;

  ecap_top #(.NCH(NCH), .CNT_W(32), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cap_pin(cap_pin), .irq(irq)
  );

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_fire <= rd_en;
  end

  // scoreboard monitor: compare each returned read against the queued prediction
  always @(negedge clk) begin
    if (rd_fire && q_exp.size() > 0) begin
      logic [AW-1:0] a;
      logic [DW-1:0] e;
      string t;
      a = q_addr.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      total++;
      if (rd_data !== e) begin
        bad++;
        $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h", t, a, rd_data, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string t, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d, output int edge_idx);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(posedge clk); #1;
    edge_idx = cyc;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string t);
    @(negedge clk);
    q_addr.push_back(AW'(a));
    q_exp.push_back(DW'(exp));
    q_tag.push_back(t);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(posedge clk); #1;
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pin_set(input int ch, input bit v, output int edge_idx);
    @(posedge clk); #1;
    cap_pin[ch] = v;
    edge_idx = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 20000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    int w, t, t2, dummy, exp0;
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(1);

    // R1 reset state
    check(irq == 1'b0, "R1 irq", int'(irq), 0);
    rd(32'h50, 0, "R1 ctrl");
    rd(32'h54, 0, "R1 ien");
    rd(32'h58, 0, "R1 stat");
    rd(32'h10, 0, "R1 capv0");
    rd(32'h30, 0, "R1 edge0");

    // R5 edge-select fields: ch0 rise, ch1 fall, ch2 both, ch3 off
    wr(32'h30, 1, dummy);
    wr(32'h34, 2, dummy);
    wr(32'h38, 3, dummy);
    wr(32'h3C, 0, dummy);
    rd(32'h34, 2, "R5 edge1");
    rd(32'h38, 3, "R5 edge2");
    wr(32'h54, 32'h02, dummy);
    rd(32'h54, 32'h02, "R6 ien");

    // R3 enable with divider 0
    wr(32'h50, 32'h400, w);
    rd(32'h50, 32'h400, "R4 ctrl");
    idle(5);
    pin_set(0, 1'b1, t);
    exp0 = t + 2 - w;
    idle(6);
    rd(32'h10, exp0, "R3 R9 capv0 div0");
    rd(32'h58, 32'h02, "R6 stat ch0");
    check(irq == 1'b1, "R8 irq enabled flag", int'(irq), 1);

    // R2 disabled channel and wrong-direction edge ignored
    pin_set(3, 1'b1, dummy);
    pin_set(1, 1'b1, dummy);
    idle(6);
    rd(32'h58, 32'h02, "R2 off and rise-on-fall ignored");
    rd(32'h1C, 0, "R2 capv3 untouched");
    pin_set(1, 1'b0, t);
    idle(6);
    rd(32'h14, t + 2 - w, "R2 fall capture ch1");
    rd(32'h58, 32'h06, "R2 stat ch0 ch1");

    // R7 selective acknowledge; R8 mask
    wr(32'h5C, 32'h02, dummy);
    idle(2);
    rd(32'h58, 32'h04, "R7 only ch0 cleared");
    check(irq == 1'b0, "R8 masked flag no irq", int'(irq), 0);

    // R2 both-edge channel takes the later edge
    pin_set(2, 1'b1, dummy);
    idle(4);
    pin_set(2, 1'b0, t);
    idle(6);
    rd(32'h18, t + 2 - w, "R2 both edges ch2");
    wr(32'h5C, 32'h1FF, dummy);
    idle(2);
    rd(32'h58, 0, "R7 full clear");

    // R4 disabled: edges ignored, counter held
    wr(32'h50, 32'h0, dummy);
    pin_set(0, 1'b0, dummy);
    idle(5);
    pin_set(0, 1'b1, dummy);
    idle(6);
    rd(32'h58, 0, "R4 no flag while off");
    rd(32'h10, exp0, "R4 capv0 kept while off");

    // R3 divider 3
    wr(32'h50, 32'h430, w);
    rd(32'h50, 32'h430, "R3 ctrl divider field");
    pin_set(0, 1'b0, dummy);
    idle(9);
    pin_set(0, 1'b1, t);
    idle(6);
    rd(32'h10, (t + 2 - w) / 4, "R3 capv0 div3");
    wr(32'h5C, 32'h1FF, dummy);

    // R7 capture and acknowledge in the same cycle: flag survives
    pin_set(2, 1'b1, t2);
    idle(1);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = AW'(32'h5C); wr_data = 32'h1FF;
    @(posedge clk); #1;
    check(cyc == t2 + 3, "R9 ack aligned with capture edge", cyc, t2 + 3);
    wr_en = 1'b0;
    idle(2);
    rd(32'h58, 32'h08, "R7 set wins over clear");

    idle(3);
    finish_run();
  end

endmodule